// File: doc/BRIEF.md
# Four-Bit Lookahead Adder Slice

A purely combinational 4-bit adder. Each bit position forms a carry-generate term and a carry-propagate term from its two operand bits. Every internal carry, including the carry-out, is then built directly from those terms and the incoming carry as one two-level AND-OR expression. No carry is computed from the carry below it, so all carries settle at the same depth.

The slice also exports a group-generate and a group-propagate pair. These describe the slice as a whole, so a higher lookahead level can derive the carry entering each slice without waiting on the slice below. That level uses the same carry equations, fed with group terms in place of bit terms.

The block has no clock, no state and no handshake. Outputs follow the operands after the combinational delay. The group of four bits keeps the widest product term at five inputs.

Top module: `cla4_slice`

## Requirements
- R1: `sum_o` equals the low four bits of `opa_i + opb_i + cin_i` for every one of the 512 input combinations.
- R2: `cout_o` equals bit 4 of `opa_i + opb_i + cin_i`.
- R3: `grp_prop_o` is 1 exactly when every bit position has at least one operand bit set, that is `(opa_i | opb_i) == 4'hF`.
- R4: `grp_gen_o` is 1 exactly when `opa_i + opb_i` exceeds 15, meaning the slice produces a carry-out with no carry-in.
- R5: `cout_o` always equals `grp_gen_o | (grp_prop_o & cin_i)`.
- R6: `grp_gen_o` and `grp_prop_o` do not depend on `cin_i`. For a fixed pair of operands, both values are the same for `cin_i` = 0 and `cin_i` = 1.
- R7: When the two operands are bitwise complements (`opa_i ^ opb_i == 4'hF`), the carry-in travels across all four positions. In that case `cout_o` equals `cin_i` and `sum_o` equals `4'hF + cin_i` truncated to four bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | First operand |
| opb_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Four-bit sum |
| cout_o | output | 1 | Carry out of bit 3 |
| grp_prop_o | output | 1 | Slice passes an incoming carry through |
| grp_gen_o | output | 1 | Slice creates a carry by itself |

## Verification
The bench sweeps every operand pair with both carry-in values and compares sum and carry-out against the arithmetic sum. This covers all carry lengths, from a carry that dies at once to one that crosses all four bits. For each pair, the group terms are checked against two independent arithmetic definitions and compared between the two carry-in values, which shows they do not depend on the carry-in. The complement-operand pairs are counted separately, because only they make the carry-out follow the carry-in through all four propagate stages.

// File: rtl/cla4_pkg.sv
package cla4_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic [SLICE_W-1:0] gen;
    logic [SLICE_W-1:0] prop;
    logic [SLICE_W-1:0] half;
  } bit_terms_t;
endpackage

// File: rtl/cla4_bit_terms.sv
module cla4_bit_terms
  import cla4_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] half_o
);
  // One cell per bit position: AND for generate, OR for propagate,
  // and a separate XOR kept only for the sum.
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] | b_i[i];
    assign half_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/cla4_carry_unit.sv
module cla4_carry_unit #(
  parameter int W = 4,
  localparam int CW = W + 1
) (
  input  logic [W-1:0]  gen_i,
  input  logic [W-1:0]  prop_i,
  input  logic          cin_i,
  output logic [CW-1:0] carry_o,
  output logic          grp_gen_o,
  output logic          grp_prop_o
);
  // Each carry is a flat OR of products. A product is one generate term
  // qualified by all propagates above it, or the carry-in qualified by
  // every propagate below the target position. No carry uses another.
  always_comb begin
    logic acc;
    logic prod;
    carry_o[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      acc = 1'b0;
      for (int k = 0; k <= i; k++) begin
        prod = gen_i[k];
        for (int m = k + 1; m <= i; m++) prod = prod & prop_i[m];
        acc = acc | prod;
      end
      prod = cin_i;
      for (int m = 0; m <= i; m++) prod = prod & prop_i[m];
      carry_o[i+1] = acc | prod;
    end
  end

  // Group terms: the top carry equation without the carry-in product,
  // and the AND of all propagates.
  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int k = 0; k < W; k++) begin
      prod = gen_i[k];
      for (int m = k + 1; m < W; m++) prod = prod & prop_i[m];
      acc = acc | prod;
    end
    grp_gen_o  = acc;
    grp_prop_o = &prop_i;
  end
endmodule

// File: rtl/cla4_sum_unit.sv
module cla4_sum_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] half_i,
  input  logic [W-1:0] carry_i,
  output logic [W-1:0] sum_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = half_i[i] ^ carry_i[i];
  end
endmodule

// File: rtl/cla4_slice.sv
module cla4_slice
  import cla4_pkg::*;
(
  input  logic [SLICE_W-1:0] opa_i,
  input  logic [SLICE_W-1:0] opb_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o,
  output logic               grp_prop_o,
  output logic               grp_gen_o
);
  localparam int CW = SLICE_W + 1;

  bit_terms_t        terms;
  logic [CW-1:0]     carry;

  cla4_bit_terms #(.W(SLICE_W)) i_terms (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .gen_o  (terms.gen),
    .prop_o (terms.prop),
    .half_o (terms.half)
  );

  cla4_carry_unit #(.W(SLICE_W)) i_carry (
    .gen_i      (terms.gen),
    .prop_i     (terms.prop),
    .cin_i      (cin_i),
    .carry_o    (carry),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  cla4_sum_unit #(.W(SLICE_W)) i_sum (
    .half_i  (terms.half),
    .carry_i (carry[SLICE_W-1:0]),
    .sum_o   (sum_o)
  );

  assign cout_o = carry[SLICE_W];
endmodule

// File: rtl/cla4_slice_chk.sv
module cla4_slice_chk
  import cla4_pkg::*;
(
  input logic [SLICE_W-1:0] opa_i,
  input logic [SLICE_W-1:0] opb_i,
  input logic               cin_i,
  input logic [SLICE_W-1:0] sum_o,
  input logic               cout_o,
  input logic               grp_prop_o,
  input logic               grp_gen_o
);
  logic [SLICE_W:0] total;
  logic [SLICE_W:0] pair;
  logic             known;

  always_comb begin
    total = {1'b0, opa_i} + {1'b0, opb_i} + {{SLICE_W{1'b0}}, cin_i};
    pair  = {1'b0, opa_i} + {1'b0, opb_i};
    known = !$isunknown({opa_i, opb_i, cin_i, sum_o, cout_o, grp_prop_o, grp_gen_o});
  end

  always_comb begin
    if (known) begin
      // R1
      sum_match_chk: assert (sum_o == total[SLICE_W-1:0]);
      // R2
      carry_out_chk: assert (cout_o == total[SLICE_W]);
      // R3
      grp_prop_chk: assert (grp_prop_o == ((opa_i | opb_i) == {SLICE_W{1'b1}}));
      // R4
      grp_gen_chk: assert (grp_gen_o == pair[SLICE_W]);
      // R5
      cout_compose_chk: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)));
      // R7
      full_path_chk: assert (!((opa_i ^ opb_i) == {SLICE_W{1'b1}}) || (cout_o == cin_i));
    end
  end
endmodule

bind cla4_slice cla4_slice_chk i_chk (.*);

// File: tb/test_cla4_slice.sv
module test_cla4_slice;
  logic       clk = 1'b0;
  logic [3:0] opa, opb;
  logic       cin;
  logic [3:0] sum;
  logic       cout, gprop, ggen;
  int         n_chk = 0;
  int         n_bad = 0;
  int         n_path = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cla4_slice i_cla4_slice (
    .opa_i      (opa),
    .opb_i      (opb),
    .cin_i      (cin),
    .sum_o      (sum),
    .cout_o     (cout),
    .grp_prop_o (gprop),
    .grp_gen_o  (ggen)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0h b=%0h cin=%0d actual=%0h expected=%0h",
               req, opa, opb, cin, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(negedge clk);
    opa = 4'(a);
    opb = 4'(b);
    cin = c[0];
    #2;
  endtask

  initial begin
    opa = '0; opb = '0; cin = 1'b0;
    // Idle pattern: zero operands give zero on every output (R1, R3, R4)
    apply(0, 0, 0);
    check("R1 idle sum", int'(sum), 0);
    check("R2 idle cout", int'(cout), 0);
    check("R3 idle prop", int'(gprop), 0);
    check("R4 idle gen", int'(ggen), 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int gen0;
        int prop0;
        for (int c = 0; c < 2; c++) begin
          int tot;
          tot = a + b + c;
          apply(a, b, c);
          check("R1 sum", int'(sum), tot % 16);
          check("R2 cout", int'(cout), tot / 16);
          check("R3 grp_prop", int'(gprop), ((a | b) == 15) ? 1 : 0);
          check("R4 grp_gen", int'(ggen), (a + b > 15) ? 1 : 0);
          check("R5 compose", int'(cout), int'(ggen | (gprop & c[0])));
          if (c == 0) begin
            gen0  = int'(ggen);
            prop0 = int'(gprop);
          end else begin
            check("R6 gen vs cin", int'(ggen), gen0);
            check("R6 prop vs cin", int'(gprop), prop0);
          end
          if ((a ^ b) == 15) begin
            n_path++;
            check("R7 cout follows cin", int'(cout), c);
            check("R7 sum", int'(sum), (15 + c) % 16);
          end
        end
      end
    end
    // R7: exactly 16 complement pairs times two carry-in values
    check("R7 path count", n_path, 32);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule